// File: doc/BRIEF.md
# Interrupt Status-Word Exchange Unit

This block decides when an interrupt is taken and performs the processor state change that goes with it. It keeps a single 32-bit current status word and two banks of six words each. One bank is the entry bank: the status word a class installs when it is taken. The other is the save bank: the status word that was current when that class was last taken. Six interrupt classes raise request lines: supervisor call, I/O, external, restart, program check and machine check. The supervisor-call line pulses when the running program executes its system-call instruction. Program check covers faults such as divide by zero, arithmetic overflow, an unknown opcode, an address past the end of memory, and a privileged operation attempted in user mode. The other classes come from outside the running program.

Each request is held in a pending bit. A class is taken only when the enable bit for that class in the current status word is set. When a class is taken, one clock edge copies the current word into that class's save slot and loads the class's entry word in its place. There is no vector table and no stack. A handler returns by loading a word through the restore port. Software fills the entry bank through a write port and reads the save bank through a read port. The rest of the processor sees the next-instruction address and the supervisor flag of the current word.

Status word layout: bits [5:0] are the class enable mask, bit 6 is the supervisor flag, and bits [31:7] are the next-instruction address. Class codes are 0 supervisor call, 1 I/O, 2 external, 3 restart, 4 program check and 5 machine check. The enable bit of a class sits at the position given by its class code.

Top module: `psw_swap_unit`

## Requirements
- R1: While rst_n is low, and after it is released, the current word, all pending bits, every entry slot and every save slot are zero, and taken_o is low.
- R2: A request sets its class's pending bit at the next clock edge. A pending class is taken at the following edge, but only if its enable bit (bit = class code) is set in the current word held before that edge.
- R3: Taking class c, in one edge, writes the current word into save slot c and loads entry slot c as the new current word.
- R4: After each edge that takes a class, taken_o is high for exactly that cycle and taken_class_o gives the class code (0 SVC, 1 I/O, 2 external, 3 restart, 4 program check, 5 machine check).
- R5: When several enabled classes are pending, the first in this order is taken: machine check (5), program check (4), supervisor call (0), external (2), I/O (1), restart (3).
- R6: I/O, external, restart and machine-check requests stay pending while their class is disabled, and are taken once it is enabled.
- R7: Supervisor-call and program-check pending bits are cleared at any edge where their enable bit in the current word is zero, so such requests are dropped.
- R8: With ld_psw_i high, the current word becomes ld_psw_word_i at the next edge, unless a class is taken at that edge: then the swap wins and the load is discarded. With neither event, the current word holds.
- R9: An entry-slot write with npsw_sel_i below 6 updates that slot at the edge. A swap of the same class at that edge uses the slot's previous contents. Selects 6 and 7 write nothing.
- R10: next_addr_o is current-word bits [31:7] and supervisor_o is bit 6. opsw_rdata_o returns save slot opsw_sel_i, or zero for selects 6 and 7.
- R11: A taken class's pending bit is cleared at the edge that takes it. A new request for the same class at that same edge leaves the bit set, so the class is taken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req_i | input | 6 | Request lines, one per class code |
| ld_psw_i | input | 1 | Load ld_psw_word_i into the current word |
| ld_psw_word_i | input | 32 | Word restored on return |
| npsw_we_i | input | 1 | Entry-slot write strobe |
| npsw_sel_i | input | 3 | Entry slot to write |
| npsw_wdata_i | input | 32 | Entry-slot write data |
| opsw_sel_i | input | 3 | Save slot to read |
| opsw_rdata_o | output | 32 | Selected save slot contents |
| cur_psw_o | output | 32 | Current status word |
| next_addr_o | output | 25 | Next-instruction address field |
| supervisor_o | output | 1 | Supervisor flag |
| taken_o | output | 1 | One-cycle pulse per class taken |
| taken_class_o | output | 3 | Code of the class taken |

## Verification
A single request arriving while its class is masked, followed by an unmasking load, shows whether the unit holds the request or drops it for each class group. All six requests at once, with every entry word re-enabling all classes, give a chain of back-to-back swaps whose order shows the priority. Swaps that coincide with a restore load, with an entry-slot write to the same class, or with a repeat request of the same class show which event wins at that edge. A long stretch of random requests, loads, slot writes and read selects is then checked against a behavioural model on every cycle, catching mismatches in the save bank and the current word that the directed cases miss.

// File: rtl/psw_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, status-word field positions and the class
// priority ranking for the status-word exchange unit.
// Assumes: six classes; status word = {address, supervisor, enable mask}.
package psw_pkg;

    localparam int N_CLASSES  = 6;
    localparam int PSW_BITS   = 32;
    localparam int CLS_BITS   = $clog2(N_CLASSES);
    localparam int SUP_POS    = N_CLASSES;
    localparam int ADDR_LSB   = N_CLASSES + 1;
    localparam int ADDR_BITS  = PSW_BITS - ADDR_LSB;

    typedef enum logic [CLS_BITS-1:0] {
        CLS_SVC     = 3'd0,
        CLS_IO      = 3'd1,
        CLS_EXT     = 3'd2,
        CLS_RESTART = 3'd3,
        CLS_PROG    = 3'd4,
        CLS_MACH    = 3'd5
    } irq_class_e;

    // Classes whose pending bit is discarded while masked (SVC, program check).
    localparam logic [N_CLASSES-1:0] DROP_WHEN_MASKED = 6'b01_0001;

    // Rank 0 is the highest priority.
    function automatic logic [CLS_BITS-1:0] rank_to_class(input int rank);
        case (rank)
            0:       return CLS_MACH;
            1:       return CLS_PROG;
            2:       return CLS_SVC;
            3:       return CLS_EXT;
            4:       return CLS_IO;
            default: return CLS_RESTART;
        endcase
    endfunction

endpackage

// File: rtl/irq_pending.sv
`timescale 1ns/1ps
// Module: irq_pending
// Holds one pending bit per class. A request sets its bit; the class taken
// at this edge has its bit cleared, but a coincident new request wins.
// Classes flagged in DROP keep a bit only while their enable mask bit is set.
// Assumes: take_cls is meaningful only when take_vld is high.
module irq_pending #(
    parameter int                  N    = 6,
    parameter int                  CW   = 3,
    parameter logic [N-1:0]        DROP = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  mask,
    input  logic          take_vld,
    input  logic [CW-1:0] take_cls,
    output logic [N-1:0]  pend
);

    logic [N-1:0] pend_q;
    logic [N-1:0] take_bits;
    logic [N-1:0] pend_nxt;

    // Decode the class being taken into a one-hot clear vector.
    always_comb begin
        take_bits = '0;
        for (int i = 0; i < N; i++) begin
            if (take_vld && (take_cls == CW'(i))) begin
                take_bits[i] = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cls
        if (DROP[g]) begin : g_drop
            // Droppable class: bit survives only while enabled.
            assign pend_nxt[g] = ((pend_q[g] & ~take_bits[g]) | req[g]) & mask[g];
        end else begin : g_hold
            // Held class: bit waits for the enable.
            assign pend_nxt[g] = (pend_q[g] & ~take_bits[g]) | req[g];
        end
    end

    // Pending register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_nxt;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/class_arbiter.sv
`timescale 1ns/1ps
// Module: class_arbiter
// Combinational fixed-priority pick among pending classes that are enabled
// in the current status word. Ranking comes from psw_pkg::rank_to_class.
// Assumes: N does not exceed the number of ranks in the package function.
module class_arbiter
    import psw_pkg::*;
#(
    parameter int N  = 6,
    parameter int CW = 3
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  mask,
    output logic          vld,
    output logic [CW-1:0] cls
);

    logic [N-1:0] eligible;

    assign eligible = pend & mask;

    // Walk from lowest to highest rank so the highest eligible one is kept.
    always_comb begin
        vld = 1'b0;
        cls = '0;
        for (int r = N - 1; r >= 0; r--) begin
            if (eligible[rank_to_class(r)]) begin
                vld = 1'b1;
                cls = CW'(rank_to_class(r));
            end
        end
    end

endmodule

// File: rtl/psw_store.sv
`timescale 1ns/1ps
// Module: psw_store
// Current status word plus per-class entry and save slots. A swap saves the
// current word into the class's save slot and installs its entry word; a
// restore load applies only when no swap happens. Entry writes land after
// the swap reads the slot. Save bank has a combinational read port.
// Assumes: swap_cls < N whenever swap_vld is high.
module psw_store #(
    parameter int N  = 6,
    parameter int W  = 32,
    parameter int CW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               swap_vld,
    input  logic [CW-1:0]      swap_cls,
    input  logic               ld_en,
    input  logic [W-1:0]       ld_word,
    input  logic               nw_we,
    input  logic [CW-1:0]      nw_sel,
    input  logic [W-1:0]       nw_data,
    input  logic [CW-1:0]      rd_sel,
    output logic [W-1:0]       rd_data,
    output logic [W-1:0]       cur,
    output logic [N-1:0][W-1:0] new_bank,
    output logic [N-1:0][W-1:0] old_bank
);

    logic [W-1:0]          cur_q;
    logic [N-1:0][W-1:0]   new_q;
    logic [N-1:0][W-1:0]   old_q;
    logic [W-1:0]          entry_word;

    // Select the entry word of the class being taken.
    always_comb begin
        entry_word = '0;
        for (int i = 0; i < N; i++) begin
            if (swap_cls == CW'(i)) begin
                entry_word = new_q[i];
            end
        end
    end

    // Current word: swap first, then restore load, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (swap_vld) begin
            cur_q <= entry_word;
        end else if (ld_en) begin
            cur_q <= ld_word;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_slot
        // Entry slot g: written by software only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                new_q[g] <= '0;
            end else if (nw_we && (nw_sel == CW'(g))) begin
                new_q[g] <= nw_data;
            end
        end

        // Save slot g: captures the current word when class g is taken.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                old_q[g] <= '0;
            end else if (swap_vld && (swap_cls == CW'(g))) begin
                old_q[g] <= cur_q;
            end
        end
    end

    // Save bank read port; out-of-range selects return zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_sel == CW'(i)) begin
                rd_data = old_q[i];
            end
        end
    end

    assign cur      = cur_q;
    assign new_bank = new_q;
    assign old_bank = old_q;

endmodule

// File: rtl/psw_swap_unit.sv
`timescale 1ns/1ps
// Module: psw_swap_unit (top)
// Interrupt entry by whole status-word exchange. Requests are latched as
// pending, filtered by the enable mask of the current word, ranked, and the
// winner is swapped in on one edge with a registered one-cycle taken pulse.
// Assumes: synchronous active-low reset; status word = {addr, sup, mask}.
module psw_swap_unit
    import psw_pkg::*;
#(
    parameter int NUM_CLASSES = N_CLASSES,
    parameter int PSW_W       = PSW_BITS
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CLASSES-1:0]         irq_req_i,
    input  logic                           ld_psw_i,
    input  logic [PSW_W-1:0]               ld_psw_word_i,
    input  logic                           npsw_we_i,
    input  logic [$clog2(NUM_CLASSES)-1:0] npsw_sel_i,
    input  logic [PSW_W-1:0]               npsw_wdata_i,
    input  logic [$clog2(NUM_CLASSES)-1:0] opsw_sel_i,
    output logic [PSW_W-1:0]               opsw_rdata_o,
    output logic [PSW_W-1:0]               cur_psw_o,
    output logic [PSW_W-NUM_CLASSES-2:0]   next_addr_o,
    output logic                           supervisor_o,
    output logic                           taken_o,
    output logic [$clog2(NUM_CLASSES)-1:0] taken_class_o
);

    localparam int CW    = $clog2(NUM_CLASSES);
    localparam int SUP_B = NUM_CLASSES;
    localparam int ADR_L = NUM_CLASSES + 1;

    logic [PSW_W-1:0]                     cur_word;
    logic [NUM_CLASSES-1:0]               en_mask;
    logic [NUM_CLASSES-1:0]               pend;
    logic                                 pick_vld;
    logic [CW-1:0]                        pick_cls;
    logic [NUM_CLASSES-1:0][PSW_W-1:0]    new_bank;
    logic [NUM_CLASSES-1:0][PSW_W-1:0]    old_bank;
    logic                                 taken_q;
    logic [CW-1:0]                        cls_q;

    assign en_mask = cur_word[NUM_CLASSES-1:0];

    irq_pending #(
        .N    (NUM_CLASSES),
        .CW   (CW),
        .DROP (DROP_WHEN_MASKED)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (irq_req_i),
        .mask     (en_mask),
        .take_vld (pick_vld),
        .take_cls (pick_cls),
        .pend     (pend)
    );

    class_arbiter #(
        .N  (NUM_CLASSES),
        .CW (CW)
    ) u_arb (
        .pend (pend),
        .mask (en_mask),
        .vld  (pick_vld),
        .cls  (pick_cls)
    );

    psw_store #(
        .N  (NUM_CLASSES),
        .W  (PSW_W),
        .CW (CW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_vld (pick_vld),
        .swap_cls (pick_cls),
        .ld_en    (ld_psw_i),
        .ld_word  (ld_psw_word_i),
        .nw_we    (npsw_we_i),
        .nw_sel   (npsw_sel_i),
        .nw_data  (npsw_wdata_i),
        .rd_sel   (opsw_sel_i),
        .rd_data  (opsw_rdata_o),
        .cur      (cur_word),
        .new_bank (new_bank),
        .old_bank (old_bank)
    );

    // Register the taken pulse and the class code alongside the swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
            cls_q   <= '0;
        end else begin
            taken_q <= pick_vld;
            if (pick_vld) begin
                cls_q <= pick_cls;
            end
        end
    end

    assign cur_psw_o     = cur_word;
    assign next_addr_o   = cur_word[PSW_W-1:ADR_L];
    assign supervisor_o  = cur_word[SUP_B];
    assign taken_o       = taken_q;
    assign taken_class_o = cls_q;

endmodule

// File: rtl/psw_swap_checker.sv
`timescale 1ns/1ps
// Module: psw_swap_checker
// Temporal properties of the exchange unit, bound into psw_swap_unit.
// Assumes: default package sizes.
module psw_swap_checker
    import psw_pkg::*;
(
    input logic                                clk,
    input logic                                rst_n,
    input logic                                ld_psw_i,
    input logic [PSW_BITS-1:0]                 ld_psw_word_i,
    input logic [PSW_BITS-1:0]                 cur_psw_o,
    input logic                                taken_o,
    input logic [CLS_BITS-1:0]                 taken_class_o,
    input logic [N_CLASSES-1:0][PSW_BITS-1:0]  new_bank,
    input logic [N_CLASSES-1:0][PSW_BITS-1:0]  old_bank
);

    logic [PSW_BITS-1:0]                 prev_cur;
    logic [N_CLASSES-1:0][PSW_BITS-1:0]  prev_new;

    // Keep last cycle's current word and entry bank.
    always_ff @(posedge clk) begin
        prev_cur <= cur_psw_o;
        prev_new <= new_bank;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (cur_psw_o == '0) && !taken_o);

    p_class_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (taken_class_o < CLS_BITS'(N_CLASSES)));

    p_enabled_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> prev_cur[taken_class_o]);

    p_old_saved_r3: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (old_bank[taken_class_o] == prev_cur));

    p_new_loaded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (cur_psw_o == prev_new[taken_class_o]));

    p_load_applies_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_psw_i |=> taken_o || (cur_psw_o == $past(ld_psw_word_i)));

    p_word_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_psw_i |=> taken_o || $stable(cur_psw_o));

endmodule

bind psw_swap_unit psw_swap_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ld_psw_i      (ld_psw_i),
    .ld_psw_word_i (ld_psw_word_i),
    .cur_psw_o     (cur_psw_o),
    .taken_o       (taken_o),
    .taken_class_o (taken_class_o),
    .new_bank      (new_bank),
    .old_bank      (old_bank)
);

// File: tb/sim_psw_swap_unit.sv
`timescale 1ns/1ps
// Bench: directed cases plus a behavioural model compared every cycle.
module sim_psw_swap_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  irq_req_i = '0;
    logic        ld_psw_i = 1'b0;
    logic [31:0] ld_psw_word_i = '0;
    logic        npsw_we_i = 1'b0;
    logic [2:0]  npsw_sel_i = '0;
    logic [31:0] npsw_wdata_i = '0;
    logic [2:0]  opsw_sel_i = '0;
    logic [31:0] opsw_rdata_o;
    logic [31:0] cur_psw_o;
    logic [24:0] next_addr_o;
    logic        supervisor_o;
    logic        taken_o;
    logic [2:0]  taken_class_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    psw_swap_unit u0 (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i),
        .ld_psw_i(ld_psw_i), .ld_psw_word_i(ld_psw_word_i),
        .npsw_we_i(npsw_we_i), .npsw_sel_i(npsw_sel_i), .npsw_wdata_i(npsw_wdata_i),
        .opsw_sel_i(opsw_sel_i), .opsw_rdata_o(opsw_rdata_o),
        .cur_psw_o(cur_psw_o), .next_addr_o(next_addr_o),
        .supervisor_o(supervisor_o), .taken_o(taken_o), .taken_class_o(taken_class_o)
    );

    // ---------------- behavioural model ----------------
    int          prio[6] = '{5, 4, 0, 2, 1, 3};
    logic [31:0] m_cur;
    logic [31:0] m_new[6];
    logic [31:0] m_old[6];
    logic [5:0]  m_pend;
    logic        m_taken;
    int          m_cls;
    int          pick;
    logic [5:0]  pre_mask;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cur = '0; m_pend = '0; m_taken = 1'b0; m_cls = 0;
            for (int i = 0; i < 6; i++) begin m_new[i] = '0; m_old[i] = '0; end
        end else begin
            pre_mask = m_cur[5:0];
            pick = -1;
            for (int r = 0; r < 6; r++)
                if (pick < 0 && m_pend[prio[r]] && pre_mask[prio[r]]) pick = prio[r];
            if (pick >= 0) begin
                m_old[pick] = m_cur;
                m_cur = m_new[pick];
                m_pend[pick] = 1'b0;
                m_taken = 1'b1;
                m_cls = pick;
            end else begin
                m_taken = 1'b0;
                if (ld_psw_i) m_cur = ld_psw_word_i;
            end
            if (npsw_we_i && npsw_sel_i < 3'd6) m_new[npsw_sel_i] = npsw_wdata_i;
            for (int c = 0; c < 6; c++) begin
                if (irq_req_i[c]) m_pend[c] = 1'b1;
                if ((c == 0 || c == 4) && !pre_mask[c]) m_pend[c] = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R3 model current word", cur_psw_o, m_cur);
            chk("R4 model taken", {31'd0, taken_o}, {31'd0, m_taken});
            if (m_taken) chk("R4 model class", {29'd0, taken_class_o}, 32'(m_cls));
            chk("R10 model save read", opsw_rdata_o,
                (opsw_sel_i < 3'd6) ? m_old[opsw_sel_i] : 32'd0);
            chk("R10 model address", {7'd0, next_addr_o}, {7'd0, m_cur[31:7]});
        end
    end

    // ---------------- directed stimulus ----------------
    function automatic logic [31:0] nval(input int c);
        return {25'(12'hA00 + c), 1'b1, 6'h3F};
    endfunction

    localparam logic [31:0] L1 = {25'h55, 1'b0, 6'h3F};
    localparam logic [31:0] L0 = {25'h10, 1'b0, 6'h00};
    localparam logic [31:0] WW = {25'h1ABCD, 1'b0, 6'h3F};

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_take(input string tag, input int c);
        chk({tag, " taken"}, {31'd0, taken_o}, 32'd1);
        chk({tag, " class"}, {29'd0, taken_class_o}, 32'(c));
    endtask

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk("R1 current word", cur_psw_o, 32'd0);
        chk("R1 taken", {31'd0, taken_o}, 32'd0);
        rst_n = 1'b1;
        tick();
        for (int s = 0; s < 8; s++) begin
            opsw_sel_i = 3'(s); #1;
            chk("R1 save slot zero", opsw_rdata_o, 32'd0);
        end
        opsw_sel_i = 3'd0;
        // R9: fill entry slots; select 6 must write nothing
        for (int c = 0; c < 7; c++) begin
            npsw_we_i = 1'b1; npsw_sel_i = 3'(c);
            npsw_wdata_i = (c < 6) ? nval(c) : 32'hDEAD_BEEF;
            tick();
        end
        npsw_we_i = 1'b0;
        chk("R9 write leaves current word", cur_psw_o, 32'd0);

        // R2/R6: I/O request while masked is held, taken after enable
        irq_req_i = 6'b00_0010; tick(); irq_req_i = '0; tick();
        chk("R2 masked not taken", {31'd0, taken_o}, 32'd0);
        ld_psw_i = 1'b1; ld_psw_word_i = L1; tick(); ld_psw_i = 1'b0;
        chk("R8 load applied", cur_psw_o, L1);
        chk("R8 no take on load edge", {31'd0, taken_o}, 32'd0);
        tick();
        expect_take("R6 held I/O", 1);
        chk("R3 entry loaded", cur_psw_o, nval(1));
        opsw_sel_i = 3'd1; #1;
        chk("R3 old word saved", opsw_rdata_o, L1);
        chk("R10 address field", {7'd0, next_addr_o}, {7'd0, nval(1) >> 7});
        chk("R10 supervisor flag", {31'd0, supervisor_o}, 32'd1);
        tick();
        chk("R4 pulse one cycle", {31'd0, taken_o}, 32'd0);

        // R7: SVC while masked is dropped
        ld_psw_i = 1'b1; ld_psw_word_i = L0; tick(); ld_psw_i = 1'b0;
        irq_req_i = 6'b00_0001; tick(); irq_req_i = '0;
        ld_psw_i = 1'b1; ld_psw_word_i = L1; tick(); ld_psw_i = 1'b0;
        tick();
        chk("R7 SVC dropped", {31'd0, taken_o}, 32'd0);

        // R7/R6: program check and external pending, then mask cleared
        irq_req_i = 6'b01_0100; ld_psw_i = 1'b1; ld_psw_word_i = L0; tick();
        irq_req_i = '0; ld_psw_i = 1'b0; tick();
        chk("R6 masked hold", {31'd0, taken_o}, 32'd0);
        ld_psw_i = 1'b1; ld_psw_word_i = L1; tick(); ld_psw_i = 1'b0;
        tick();
        expect_take("R6 external kept", 2);
        tick();
        chk("R7 program check dropped", {31'd0, taken_o}, 32'd0);

        // R5: all six at once, entry words re-enable all classes
        irq_req_i = 6'h3F; tick(); irq_req_i = '0;
        for (int k = 0; k < 6; k++) begin
            tick();
            expect_take("R5 priority order", prio[k]);
        end
        opsw_sel_i = 3'd4; #1;
        chk("R3 chain save", opsw_rdata_o, nval(5));
        tick();
        chk("R11 chain drained", {31'd0, taken_o}, 32'd0);

        // R8: load coinciding with a swap loses
        irq_req_i = 6'b00_0100; tick(); irq_req_i = '0;
        ld_psw_i = 1'b1; ld_psw_word_i = L0; tick(); ld_psw_i = 1'b0;
        expect_take("R8 swap wins", 2);
        chk("R8 swap word", cur_psw_o, nval(2));
        tick();
        chk("R8 load discarded", cur_psw_o, nval(2));

        // R9: entry write coinciding with swap of the same class
        irq_req_i = 6'b00_0010; tick(); irq_req_i = '0;
        npsw_we_i = 1'b1; npsw_sel_i = 3'd1; npsw_wdata_i = WW; tick(); npsw_we_i = 1'b0;
        expect_take("R9 coincident write", 1);
        chk("R9 swap used old entry", cur_psw_o, nval(1));
        irq_req_i = 6'b00_0010; tick(); irq_req_i = '0; tick();
        chk("R9 new entry used next", cur_psw_o, WW);
        chk("R10 supervisor clear", {31'd0, supervisor_o}, 32'd0);

        // R11: repeat request on the take edge keeps the bit
        irq_req_i = 6'b00_0010; tick(); tick(); irq_req_i = '0;
        expect_take("R11 first take", 1);
        tick();
        expect_take("R11 second take", 1);
        tick();
        chk("R11 cleared after", {31'd0, taken_o}, 32'd0);

        opsw_sel_i = 3'd7; #1;
        chk("R10 select 7 reads zero", opsw_rdata_o, 32'd0);

        // Random traffic checked by the model every cycle
        for (int n = 0; n < 3000; n++) begin
            irq_req_i     = 6'($urandom) & 6'($urandom) & 6'($urandom);
            ld_psw_i      = ($urandom % 8) == 0;
            ld_psw_word_i = $urandom;
            npsw_we_i     = ($urandom % 6) == 0;
            npsw_sel_i    = 3'($urandom);
            npsw_wdata_i  = $urandom;
            opsw_sel_i    = 3'($urandom);
            tick();
        end
        irq_req_i = '0; ld_psw_i = 1'b0; npsw_we_i = 1'b0;
        tick();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule